// File: doc/BRIEF.md
# Dual cascaded line delay memory

This block delays a stream of bytes by one and by two scan lines at the same time. The write side stores each incoming byte into the first bank on its own clock. The read side, on a separate clock, returns the first bank's word on the one-line output. On the same edge it returns the second bank's word on the two-line output and copies the one-line byte into the second bank at that address. As a result, the second output always trails the first by exactly one more line. Filters that need the lines above and below a pixel can take all three rows from the live input and the two outputs.

Each side has an active-low enable and an active-low reset that returns its address pointers to word 0. The line length is set by the resets rather than by a register. Resetting both sides every 5120 cycles gives a full-line delay. Resetting them every n cycles, or placing the write reset n cycles ahead of the read reset, gives an n-word delay. Each output carries a registered valid flag in place of a high-impedance pad state.

Top module: `dual_line_delay`

## Requirements
- R1: On a write-clock edge with `wen_n` low, `din` is stored into bank 1 at the write pointer and the pointer advances by one. With `wen_n` high, nothing is stored and the pointer holds.
- R2: With `wrst_n` low on a write-clock edge, the write pointer is taken as 0 for that edge. If writing is enabled, `din` lands at word 0 and the next write goes to word 1.
- R3: On a read-clock edge with `ren_n` low, `q1` takes the bank 1 word at the read pointer and `q2` takes the bank 2 word at the same pointer. Both valid flags go high and the read pointer advances.
- R4: On that same enabled read edge, the byte placed on `q1` is written into bank 2 at the same address. `q2` therefore repeats, one line later, what `q1` showed.
- R5: On a read-clock edge with `ren_n` high, both valid flags go low. `q1` and `q2` keep their values, the read pointer holds, and bank 2 is not written.
- R6: With `rrst_n` low on a read-clock edge, the pointer shared by the bank 1 read and the bank 2 read and write is taken as 0. While the reset is held with reading enabled, `q1` keeps showing word 0.
- R7: Each pointer goes from word 5119 (DEPTH-1) back to word 0 when no reset arrives, so with no resets the delay is one full line of DEPTH words.
- R8: When both resets are asserted together every n cycles, `q1` equals the byte written n cycles earlier and `q2` equals the byte written 2n cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, rising edge |
| wen_n | input | 1 | Write enable, active low |
| wrst_n | input | 1 | Write pointer reset, active low, synchronous to wclk |
| din | input | W | Input byte |
| rclk | input | 1 | Read clock, rising edge |
| ren_n | input | 1 | Read enable, active low |
| rrst_n | input | 1 | Read-side pointer reset, active low, synchronous to rclk |
| q1 | output | W | One-line delayed byte |
| q1_vld | output | 1 | q1 driven (low while reading is disabled) |
| q2 | output | W | Two-line delayed byte |
| q2_vld | output | 1 | q2 driven (low while reading is disabled) |

## Verification
The hardest state to reach is a line that has wrapped twice with no reset. Only then does `q2` carry bytes that passed through bank 1, then the copy path, then a second full lap of bank 2. The stimulus runs more than two full lines of 5120 words back to back before any other activity, and checks each output against input bytes saved one and two lines earlier. Random stretches of disabled reads and writes then move the two pointers apart. A per-address model of both banks follows the pointers through these stretches, and short reset periods check the programmable delay.

// File: rtl/dual_line_delay.sv
module dual_line_delay #(
  parameter int DEPTH = 5120,
  parameter int W     = 8
) (
  input  logic         wclk,
  input  logic         wen_n,
  input  logic         wrst_n,
  input  logic [W-1:0] din,
  input  logic         rclk,
  input  logic         ren_n,
  input  logic         rrst_n,
  output logic [W-1:0] q1,
  output logic         q1_vld,
  output logic [W-1:0] q2,
  output logic         q2_vld
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  bank1 [DEPTH];
  logic [W-1:0]  bank2 [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + AW'(1);
  endfunction

  wire [AW-1:0] wa = wrst_n ? wptr : '0;
  wire [AW-1:0] ra = rrst_n ? rptr : '0;
  wire [W-1:0]  b1_word = bank1[ra];

  always_ff @(posedge wclk) begin
    if (!wen_n) begin
      bank1[wa] <= din;
      wptr      <= step_addr(wa);
    end else begin
      wptr      <= wa;
    end
  end

  always_ff @(posedge rclk) begin
    if (!ren_n) begin
      q1        <= b1_word;
      q2        <= bank2[ra];
      bank2[ra] <= b1_word;
      rptr      <= step_addr(ra);
    end else begin
      rptr      <= ra;
    end
    q1_vld <= !ren_n;
    q2_vld <= !ren_n;
  end
endmodule

// File: rtl/dual_line_delay_chk.sv
module dual_line_delay_chk #(
  parameter int DEPTH = 5120,
  parameter int W     = 8,
  parameter int AW    = 13
) (
  input logic          wclk,
  input logic          wen_n,
  input logic          wrst_n,
  input logic          rclk,
  input logic          ren_n,
  input logic          rrst_n,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [W-1:0]  q1,
  input logic [W-1:0]  q2,
  input logic          q1_vld,
  input logic          q2_vld
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic r_armed = 1'b0;
  logic w_armed = 1'b0;
  always_ff @(posedge rclk) if (!rrst_n) r_armed <= 1'b1;
  always_ff @(posedge wclk) if (!wrst_n) w_armed <= 1'b1;

  // R1
  w_advance_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && !wen_n && wptr != LAST) |=> (wptr == $past(wptr) + AW'(1)));
  // R1
  w_hold_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && wen_n) |=> $stable(wptr));
  // R2
  w_reset_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    !wrst_n |=> (wptr == ($past(wen_n) ? AW'(0) : AW'(1))));
  // R3
  r_valid_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    !ren_n |=> (q1_vld && q2_vld));
  // R5
  r_idle_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    ren_n |=> (!q1_vld && !q2_vld && $stable(q1) && $stable(q2)));
  // R5
  r_hold_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (ren_n && rrst_n) |=> $stable(rptr));
  // R6
  r_reset_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (!rrst_n && !ren_n) |=> (rptr == AW'(1)));
  // R7
  r_wrap_chk: assert property (@(posedge rclk) disable iff (!r_armed)
    (rrst_n && !ren_n && rptr == LAST) |=> (rptr == '0));
  // R7
  w_wrap_chk: assert property (@(posedge wclk) disable iff (!w_armed)
    (wrst_n && !wen_n && wptr == LAST) |=> (wptr == '0));
endmodule

bind dual_line_delay dual_line_delay_chk #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_chk (
  .wclk(wclk), .wen_n(wen_n), .wrst_n(wrst_n),
  .rclk(rclk), .ren_n(ren_n), .rrst_n(rrst_n),
  .wptr(wptr), .rptr(rptr), .q1(q1), .q2(q2),
  .q1_vld(q1_vld), .q2_vld(q2_vld)
);

// File: tb/dual_line_delay_tb.sv
module dual_line_delay_tb;
  localparam int DEPTH = 5120;
  localparam int W = 8;

  logic wclk = 0, rclk = 0;
  logic wen_n = 1, wrst_n = 1, ren_n = 1, rrst_n = 1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q1, q2;
  logic q1_vld, q2_vld;

  dual_line_delay #(.DEPTH(DEPTH), .W(W)) u_dut (
    .wclk(wclk), .wen_n(wen_n), .wrst_n(wrst_n), .din(din),
    .rclk(rclk), .ren_n(ren_n), .rrst_n(rrst_n),
    .q1(q1), .q1_vld(q1_vld), .q2(q2), .q2_vld(q2_vld));

  always #10 wclk = ~wclk;
  initial begin
    #15;
    forever begin rclk = 1; #10; rclk = 0; #10; end
  end

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] m1 [DEPTH];
  logic [W-1:0] m2 [DEPTH];
  bit k1 [DEPTH];
  bit k2 [DEPTH];
  int rp = 0, wp = 0, sc = 0;
  logic [W-1:0] hist [$];
  logic [W-1:0] pq1, pq2;
  bit seen_read = 0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit ren, input bit rrst, input bit wen, input bit wrst,
                      input logic [W-1:0] d, input string tag);
    int ea;
    logic [W-1:0] e1, e2;
    bit kk1, kk2;
    ren_n = !ren; rrst_n = !rrst;
    @(posedge rclk); #2;
    ea = rrst ? 0 : rp;
    if (ren) begin
      e1 = m1[ea]; e2 = m2[ea]; kk1 = k1[ea]; kk2 = k2[ea];
      m2[ea] = e1; k2[ea] = kk1;
      rp = (ea + 1) % DEPTH;
      chk(q1_vld && q2_vld, {tag, " R3 valid"}, {14'd0, q1_vld, q2_vld}, 16'd3);
      if (kk1) chk(q1 == e1, {tag, " R3 q1"}, 16'(q1), 16'(e1));
      if (kk2) chk(q2 == e2, {tag, " R4 q2"}, 16'(q2), 16'(e2));
      seen_read = 1;
    end else begin
      rp = ea;
      chk(!q1_vld && !q2_vld, {tag, " R5 valid"}, {14'd0, q1_vld, q2_vld}, 16'd0);
      if (seen_read) chk(q1 == pq1 && q2 == pq2, {tag, " R5 hold"}, {q1, q2}, {pq1, pq2});
    end
    pq1 = q1; pq2 = q2;
    wen_n = !wen; wrst_n = !wrst; din = d;
    @(posedge wclk); #1;
    ea = wrst ? 0 : wp;
    if (wen) begin
      m1[ea] = d; k1[ea] = 1;
      wp = (ea + 1) % DEPTH;
    end else wp = ea;
    hist.push_back(d);
    sc++;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [W-1:0] v;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin k1[i] = 0; k2[i] = 0; end
    @(posedge wclk); #1;

    // reset state: both pointers cleared, reads off -> flags low (R5)
    step(0, 1, 0, 1, 8'h00, "reset");
    chk(!q1_vld && !q2_vld, "reset R5 flags", {14'd0, q1_vld, q2_vld}, 16'd0);

    // more than two full lines with no reset: R7 wrap, line delays
    step(1, 1, 1, 1, 8'($urandom), "line");
    base = sc - 1;
    for (int k = 1; k < 2 * DEPTH + 40; k++) begin
      step(1, 0, 1, 0, 8'($urandom), "line");
      if (k >= DEPTH)
        chk(q1 == hist[base + k - DEPTH], "R7 q1 one line", 16'(q1), 16'(hist[base + k - DEPTH]));
      if (k >= 2 * DEPTH)
        chk(q2 == hist[base + k - 2 * DEPTH], "R4 q2 two lines", 16'(q2), 16'(hist[base + k - 2 * DEPTH]));
    end

    // random enables, rare resets (R1 R3 R5 R6)
    for (int k = 0; k < 4000; k++)
      step(($urandom % 5) != 0, ($urandom % 97) == 0, ($urandom % 5) != 0,
           ($urandom % 89) == 0, 8'($urandom), "rand R1");

    // write reset with write enabled: din lands at word 0 (R2)
    step(0, 0, 1, 1, 8'hA5, "R2 wr");
    step(1, 1, 0, 0, 8'h00, "R2 rd");
    chk(q1 == 8'hA5, "R2 word0", 16'(q1), 16'hA5);

    // read reset held with reading: q1 repeats word 0 (R6)
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 0, 0, 8'h00, "R6");
      chk(q1 == 8'hA5, "R6 held word0", 16'(q1), 16'hA5);
    end

    // disabled write leaves word 0 alone (R1)
    step(0, 0, 0, 1, 8'h3C, "R1 off");
    step(1, 1, 0, 0, 8'h00, "R1 off rd");
    chk(q1 == 8'hA5, "R1 no store", 16'(q1), 16'hA5);

    // programmable delay: both resets every 7 cycles (R8)
    base = sc;
    for (int k = 0; k < 70; k++) begin
      v = 8'($urandom);
      step(1, (k % 7) == 0, 1, (k % 7) == 0, v, "R8");
      if (k >= 7)
        chk(q1 == hist[base + k - 7], "R8 q1 n delay", 16'(q1), 16'(hist[base + k - 7]));
      if (k >= 14)
        chk(q2 == hist[base + k - 14], "R8 q2 2n delay", 16'(q2), 16'(hist[base + k - 14]));
    end

    // reading off: flags drop, outputs hold (R5)
    v = q1;
    step(0, 0, 1, 0, 8'h11, "R5 off");
    chk(q1 == v && !q1_vld, "R5 q1 hold", {q1_vld, 7'd0, q1}, {8'd0, v});

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule